// File: doc/BRIEF.md
# Pseudo-static RAM refresh controller

This block is the refresh sequencer that sits beside the DRAM array of a pseudo-static memory. It watches two active-low chip enables and a shared active-low pin that serves as output enable while the chip is selected and as a refresh request while it is deselected. All three pins are passed through a two-stage synchronizer on the internal clock before any decision is made. From them the block issues single-cycle row refresh strobes, together with the 9-bit row to refresh, and a busy flag that tells the array a refresh sequence owns it.

A short low pulse on the shared pin while the chip is deselected performs one auto refresh at the row held in an internal 9-bit counter, which then advances. Holding the pin low longer than a parameterised number of clocks moves the block into self refresh, where its own interval timer keeps issuing counter-addressed strobes until the pin returns high. Every selected cycle also refreshes one row taken from the low address bits, which makes a chip-enable-only cycle a refresh of an externally chosen row. After any counter-driven refresh the block stays busy for a recovery window and defers new chip selection until that window has passed.

Top module: `psram_refresh_ctrl`

## Requirements
- R1: After reset `rf_strobe` and `rf_busy` are 0 and the internal row counter is 0, so the first counter-driven strobe carries row 0.
- R2: When both synchronized enables go low from idle, one strobe is issued with `rf_row` = {1'b0, `addr[7:0]`}; `addr[14:8]` has no effect on the row.
- R3: A low level on `oe_rfsh_n` while both enables are high issues one strobe with the current counter value on `rf_row`; the counter then steps by one.
- R4: The row counter is 9 bits and wraps from 511 to 0.
- R5: While both enables are low, a low level on `oe_rfsh_n` issues no strobe and leaves the counter unchanged.
- R6: With exactly one enable low, a low level on `oe_rfsh_n` issues no strobe, keeps `rf_busy` at 0 and leaves the counter unchanged.
- R7: If `oe_rfsh_n` stays low for more than ENTRY_CYC clocks while deselected, a second counter strobe is issued on entry to self refresh and another every INTERVAL_CYC clocks until the pin returns high; a low time of exactly ENTRY_CYC clocks gives only the single auto refresh.
- R8: `rf_busy` is 1 from the start of a counter refresh until RECOVER_CYC clocks after the synchronized pin returns high; no strobe is issued in that window, and a chip selection made during it is served on the first clock after it.
- R9: A pin change applied before rising edge 1 shows its strobe after rising edge 3, never after edge 2.
- R10: `rf_strobe` is a one-clock pulse and every strobe matches exactly one expected row refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| ce1_n | input | 1 | Chip enable one, active low |
| ce2_n | input | 1 | Chip enable two, active low |
| oe_rfsh_n | input | 1 | Output enable when selected, refresh request when deselected, active low |
| addr | input | 15 | External address; bits 7:0 give the selected-cycle row |
| rf_strobe | output | 1 | One-clock row refresh strobe to the array |
| rf_row | output | 9 | Row to refresh, valid with `rf_strobe` |
| rf_busy | output | 1 | Refresh sequence or recovery window in progress |

## Verification
A corrupted row counter shows on `rf_row` at the very next counter-driven strobe, three clocks after the refresh request pin falls, so every auto-refresh pulse doubles as a readout of the counter. A sequencer stuck in the wrong state shows either as an unexpected or missing strobe against the scoreboard or as `rf_busy` dropping too early or too late around the recovery window, which the bench samples on the exact clock it must change. A broken self-refresh timer shows as a wrong number of strobes during a long hold, visible within one interval of entry.

// File: rtl/psram_rf_pkg.sv
package psram_rf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_RFLOW,
        ST_SELF,
        ST_RECOV
    } rf_state_e;

    typedef enum logic {
        SRC_EXT,
        SRC_CTR
    } row_src_e;

    typedef struct packed {
        logic sel;
        logic desel;
        logic oe_low;
        logic rf_req;
    } pin_view_t;

    typedef struct packed {
        logic     strobe;
        row_src_e src;
    } rf_cmd_t;

    function automatic pin_view_t decode_pins(input logic ce1_n, input logic ce2_n,
                                              input logic oe_n);
        pin_view_t v;
        v.sel    = !ce1_n && !ce2_n;
        v.desel  = ce1_n && ce2_n;
        v.oe_low = !oe_n;
        v.rf_req = v.desel && v.oe_low;
        return v;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/psram_rf_sync.sv
module psram_rf_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/psram_rf_row_ctr.sv
module psram_rf_row_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    // R4: one step per advance, modulo 2**W
    p_ctr_step_r4: assert property (@(posedge clk) disable iff (rst)
        adv |=> cnt == W'($past(cnt) + 1'b1));
    p_ctr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));
endmodule

// File: rtl/psram_rf_fsm.sv
module psram_rf_fsm
    import psram_rf_pkg::*;
#(
    parameter int ENTRY_CYC    = 1000,
    parameter int INTERVAL_CYC = 1900,
    parameter int RECOVER_CYC  = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_view_t pv,
    output rf_cmd_t   cmd_nxt,
    output logic      busy
);
    localparam int MAXC  = max3(ENTRY_CYC, INTERVAL_CYC, RECOVER_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
    localparam logic [CNT_W-1:0] INTV_LAST  = CNT_W'(INTERVAL_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(RECOVER_CYC - 1);

    rf_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d        = state_q;
        cnt_d          = cnt_q;
        cmd_nxt.strobe = 1'b0;
        cmd_nxt.src    = SRC_CTR;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (pv.sel) begin
                    state_d        = ST_ACTIVE;
                    cmd_nxt.strobe = 1'b1;
                    cmd_nxt.src    = SRC_EXT;
                end else if (pv.rf_req) begin
                    state_d        = ST_RFLOW;
                    cmd_nxt.strobe = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (!pv.sel) state_d = ST_IDLE;
            end
            ST_RFLOW: begin
                if (!pv.oe_low) begin
                    state_d = ST_RECOV;
                    cnt_d   = '0;
                end else if (cnt_q == ENTRY_LAST) begin
                    state_d        = ST_SELF;
                    cnt_d          = '0;
                    cmd_nxt.strobe = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SELF: begin
                if (!pv.oe_low) begin
                    state_d = ST_RECOV;
                    cnt_d   = '0;
                end else if (cnt_q == INTV_LAST) begin
                    cnt_d          = '0;
                    cmd_nxt.strobe = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RECOV: begin
                if (cnt_q == REC_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign busy = (state_q == ST_RFLOW) || (state_q == ST_SELF) || (state_q == ST_RECOV);

    // R5: an active cycle never produces a counter refresh
    p_active_no_ctr_r5: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_ACTIVE |-> !(cmd_nxt.strobe && cmd_nxt.src == SRC_CTR));
    // R8: busy only ends once the full recovery count has elapsed
    p_recover_len_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(state_q) == ST_RECOV && $past(cnt_q) == REC_LAST));
    // R8: nothing is strobed while recovering
    p_recov_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_RECOV |-> !cmd_nxt.strobe);
endmodule

// File: rtl/psram_refresh_ctrl.sv
module psram_refresh_ctrl
    import psram_rf_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int ROW_W        = 9,
    parameter int EXT_ROW_W    = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int ENTRY_CYC    = 1000,
    parameter int INTERVAL_CYC = 1900,
    parameter int RECOVER_CYC  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              oe_rfsh_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rf_strobe,
    output logic [ROW_W-1:0]  rf_row,
    output logic              rf_busy
);
    localparam int PAD_W = ROW_W - EXT_ROW_W;

    logic [2:0]       pins_s;
    pin_view_t        pv;
    rf_cmd_t          cmd_nxt;
    logic [ROW_W-1:0] ctr_row, ext_row, row_d;
    logic             ctr_adv;
    row_src_e         src_q;
    logic             unused_addr_hi;

    psram_rf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ce1_n, ce2_n, oe_rfsh_n}),
        .q   (pins_s)
    );

    assign pv = decode_pins(pins_s[2], pins_s[1], pins_s[0]);

    psram_rf_fsm #(
        .ENTRY_CYC    (ENTRY_CYC),
        .INTERVAL_CYC (INTERVAL_CYC),
        .RECOVER_CYC  (RECOVER_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pv      (pv),
        .cmd_nxt (cmd_nxt),
        .busy    (rf_busy)
    );

    assign ctr_adv = cmd_nxt.strobe && (cmd_nxt.src == SRC_CTR);

    psram_rf_row_ctr #(.W(ROW_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .adv (ctr_adv),
        .cnt (ctr_row)
    );

    assign ext_row        = {{PAD_W{1'b0}}, addr[EXT_ROW_W-1:0]};
    assign unused_addr_hi = ^addr[ADDR_W-1:EXT_ROW_W];
    assign row_d          = (cmd_nxt.src == SRC_EXT) ? ext_row : ctr_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_strobe <= 1'b0;
            rf_row    <= '0;
            src_q     <= SRC_CTR;
        end else begin
            rf_strobe <= cmd_nxt.strobe;
            src_q     <= cmd_nxt.src;
            if (cmd_nxt.strobe) rf_row <= row_d;
        end
    end

    // R2: rows from the pins never set the bits above the external field
    p_ext_row_top_r2: assert property (@(posedge clk) disable iff (rst)
        (rf_strobe && src_q == SRC_EXT) |-> rf_row[ROW_W-1:EXT_ROW_W] == '0);
    // R3: counter-addressed strobes happen only while the array is held busy
    p_ctr_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (rf_strobe && src_q == SRC_CTR) |-> rf_busy);
    // R10: the strobe is a single-clock pulse
    if (ENTRY_CYC > 1 && INTERVAL_CYC > 1) begin : g_pulse_chk
        p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (rst)
            rf_strobe |=> !rf_strobe);
    end
endmodule

// File: tb/psram_refresh_ctrl_bench.sv
module psram_refresh_ctrl_bench;
    localparam int ADDR_W = 15;
    localparam int ROW_W  = 9;
    localparam int ENTRY  = 1000;
    localparam int INTV   = 1900;
    localparam int RC     = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce1_n = 1'b1;
    logic              ce2_n = 1'b1;
    logic              oe_rfsh_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              rf_strobe;
    logic [ROW_W-1:0]  rf_row;
    logic              rf_busy;

    int n_chk  = 0;
    int n_fail = 0;
    logic [ROW_W-1:0] exp_q[$];
    logic [ROW_W-1:0] exp_ctr = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    psram_refresh_ctrl #(
        .ENTRY_CYC (ENTRY), .INTERVAL_CYC (INTV), .RECOVER_CYC (RC)
    ) u_psram_refresh_ctrl (
        .clk (clk), .rst (rst), .ce1_n (ce1_n), .ce2_n (ce2_n),
        .oe_rfsh_n (oe_rfsh_n), .addr (addr),
        .rf_strobe (rf_strobe), .rf_row (rf_row), .rf_busy (rf_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: each strobe must match the next expected row (R10)
    always @(negedge clk) begin
        if (!rst && rf_strobe) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10 unexpected strobe actual=%0h expected=none", rf_row);
            end else begin
                logic [ROW_W-1:0] e;
                e = exp_q.pop_front();
                if (rf_row !== e) begin
                    n_fail++;
                    $display("FAIL R10 row actual=%0h expected=%0h", rf_row, e);
                end
            end
        end
    end

    task automatic push_ctr();
        exp_q.push_back(exp_ctr);
        exp_ctr = exp_ctr + 1'b1;
    endtask

    task automatic ce_cycle(input logic [ADDR_W-1:0] a, input int hold);
        @(negedge clk);
        addr = a; ce1_n = 1'b0; ce2_n = 1'b0;
        exp_q.push_back({1'b0, a[7:0]});
        repeat (hold) @(negedge clk);
        ce1_n = 1'b1; ce2_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // low for h clocks; expected strobes follow R3 and R7
    task automatic rf_hold(input int h);
        int n_self;
        @(negedge clk);
        oe_rfsh_n = 1'b0;
        push_ctr();
        n_self = (h > ENTRY) ? 1 + (h - ENTRY - 1) / INTV : 0;
        for (int i = 0; i < n_self; i++) push_ctr();
        repeat (h) @(negedge clk);
        oe_rfsh_n = 1'b1;
        repeat (RC + 6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 strobe after reset", rf_strobe, 0);
        check("R1 busy after reset", rf_busy, 0);

        // R9 latency and R1 first counter row, R8 busy window
        @(negedge clk);
        oe_rfsh_n = 1'b0;
        push_ctr();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 no strobe after edge 2", rf_strobe, 0);
        @(posedge clk);
        @(negedge clk);
        check("R9 strobe after edge 3", rf_strobe, 1);
        check("R8 busy during refresh", rf_busy, 1);
        repeat (3) @(negedge clk);
        oe_rfsh_n = 1'b1;
        repeat (2 + RC) @(posedge clk);
        @(negedge clk);
        check("R8 busy at end of recovery", rf_busy, 1);
        @(posedge clk);
        @(negedge clk);
        check("R8 busy released", rf_busy, 0);
        repeat (4) @(negedge clk);

        // R2 selected cycles, upper address bits ignored
        ce_cycle(15'h0012, 6);
        ce_cycle(15'h7F12, 6);
        ce_cycle(15'h00FF, 8);
        ce_cycle(15'h5A80, 5);

        // R5 refresh pin low during an active cycle
        @(negedge clk);
        addr = 15'h0033; ce1_n = 1'b0; ce2_n = 1'b0;
        exp_q.push_back(9'h033);
        repeat (5) @(negedge clk);
        oe_rfsh_n = 1'b0;
        repeat (30) @(negedge clk);
        check("R5 no busy in active cycle", rf_busy, 0);
        oe_rfsh_n = 1'b1;
        repeat (4) @(negedge clk);
        ce1_n = 1'b1; ce2_n = 1'b1;
        repeat (4) @(negedge clk);
        rf_hold(3); // R5 counter unchanged: next row checked by scoreboard

        // R6 only one enable low
        @(negedge clk);
        ce1_n = 1'b0; oe_rfsh_n = 1'b0;
        repeat (50) @(negedge clk);
        check("R6 no busy partial select", rf_busy, 0);
        check("R6 no strobe partial select", rf_strobe, 0);
        oe_rfsh_n = 1'b1; ce1_n = 1'b1;
        repeat (6) @(negedge clk);
        rf_hold(3); // R6 counter unchanged

        // R3/R4 many auto refreshes across the wrap
        for (int i = 0; i < 520; i++) rf_hold(3);
        check("R4 model counter wrapped", (exp_ctr < 9'd20), 1);

        // R7 self refresh boundaries
        rf_hold(ENTRY);
        rf_hold(ENTRY + 1);
        rf_hold(ENTRY + 3 * INTV + INTV / 2);

        // R8 selection during recovery is deferred
        @(negedge clk);
        oe_rfsh_n = 1'b0;
        push_ctr();
        repeat (6) @(negedge clk);
        oe_rfsh_n = 1'b1; addr = 15'h0C4D; ce1_n = 1'b0; ce2_n = 1'b0;
        exp_q.push_back(9'h04D);
        repeat (2 + RC) @(posedge clk);
        @(negedge clk);
        check("R8 no strobe during recovery", rf_strobe, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8 deferred select strobe", rf_strobe, 1);
        check("R8 not busy on select strobe", rf_busy, 0);
        repeat (4) @(negedge clk);
        ce1_n = 1'b1; ce2_n = 1'b1;
        repeat (8) @(negedge clk);

        check("R10 all expected strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule